// File: doc/BRIEF.md
# Float-to-posit converter

This block turns an IEEE-754 single-precision word into a posit word. The width of the posit and the size of its exponent field are parameters. It is meant for the edge of a datapath that stores values as posits but receives them as floats. Each conversion takes a fixed two-cycle latency and uses a valid strobe in each direction. A new word may be accepted on every clock.

The float is split into sign, biased exponent and mantissa. The unbiased exponent is divided by 2^ES with floor semantics. The quotient sets the regime and the non-negative remainder becomes the posit exponent. The regime run, its stop bit, the exponent and the mantissa are laid down from the MSB side of the word, and whatever does not fit is discarded. The kept bits are rounded to nearest with ties to even. Negative inputs then get the two's complement of the positive result. Zero and subnormal floats give posit zero. Infinities and NaNs give the not-a-real pattern. Magnitudes beyond the posit range clamp to the largest or smallest posit.

Top module: `f2p_conv`

## Requirements
- R1: A float whose 8-bit exponent field (bits 30:23) is 0, meaning zero or subnormal with either sign, converts to the all-zero posit.
- R2: A float whose exponent field is 255, meaning infinity or NaN with either sign, converts to not-a-real: bit NBITS-1 set and all other bits clear.
- R3: For other floats, E = field − 127, k = floor(E / 2^ES) and the posit exponent is E − k·2^ES. For k ≥ 0 the field after the sign bit starts with k+1 ones and then a zero. For k < 0 it starts with −k zeros and then a one. Any of these bits that fall past the LSB are dropped.
- R4: After the regime come ES exponent bits, MSB first, and then the 23 mantissa bits, MSB first. The NBITS-1 kept bits are rounded up when the first dropped bit is 1 and either any later dropped bit or the kept LSB is 1.
- R5: If k > NBITS-2, the magnitude becomes maxpos, which is 0 followed by NBITS-1 ones. If k < −(NBITS-2), the magnitude becomes minpos, which is the value 1.
- R6: A negative float of R3 to R5 converts to the two's complement of the result for its magnitude.
- R7: A float of R3 to R6 never converts to zero or to not-a-real.
- R8: `out_valid` rises exactly two clock edges after an edge that samples `in_valid` high, with the matching result. It stays low in every other cycle. Back-to-back inputs are accepted.
- R9: While `rst_n` is low at a clock edge, `out_valid` and `out_posit` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_float` carries a word to convert |
| in_float | input | 32 | Single-precision input word |
| out_valid | output | 1 | `out_posit` carries a result |
| out_posit | output | NBITS | Posit result |

## Verification
The assertions assume that `in_valid` is low across reset and that the parameters satisfy 0 ≤ ES ≤ 7 and NBITS ≥ 4. Under those limits the regime quotient fits its 10-bit signed register. The stimulus holds `in_valid` low during reset. Random exponents are drawn mostly within ±30 of the bias, so that values near both saturation edges and inside the normal range appear often. Random mantissas sometimes have their low bits cleared, which produces exact ties for rounding. Fully random words add zero, subnormal, infinity and NaN encodings.

// File: rtl/f2p_pkg.sv
// Shared types for the float-to-posit converter.
// Assumes nothing beyond IEEE-754 single-precision field layout.
package f2p_pkg;
    // Input class after field split
    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NAR  = 2'd1,
        CLS_NUM  = 2'd2
    } fcls_e;

    localparam int FEXP_W  = 8;
    localparam int FMAN_W  = 23;
    localparam int FBIAS   = 127;
    localparam int KREG_W  = 10;
endpackage

// File: rtl/f2p_unpack.sv
// Splits a single-precision word into class, sign, regime quotient k,
// posit exponent remainder and mantissa. Subnormals are classed as zero.
// Assumes ES <= 7 so that k fits KREG_W signed bits.
module f2p_unpack
    import f2p_pkg::*;
#(
    parameter int ES = 1,
    localparam int EW = (ES > 0) ? ES : 1
) (
    input  logic [31:0]              f_in,
    output fcls_e                    cls,
    output logic                     sign,
    output logic signed [KREG_W-1:0] k,
    output logic [EW-1:0]            ex,
    output logic [FMAN_W-1:0]        man
);
    logic [FEXP_W-1:0]        efield;
    logic signed [KREG_W-1:0] eunb;

    // field split, classification and floor division by 2^ES
    always_comb begin
        efield = f_in[30:23];
        sign   = f_in[31];
        man    = f_in[22:0];
        eunb   = $signed({2'b00, efield}) - KREG_W'(FBIAS);
        k      = eunb >>> ES;
        if (efield == '0)
            cls = CLS_ZERO;
        else if (efield == '1)
            cls = CLS_NAR;
        else
            cls = CLS_NUM;
    end

    generate
        if (ES > 0) begin : g_ex
            // remainder is the low ES bits of the two's-complement exponent
            assign ex = eunb[EW-1:0];
        end else begin : g_noex
            assign ex = '0;
        end
    endgenerate
endmodule

// File: rtl/f2p_pack.sv
// Lays the regime run, stop bit, exponent and mantissa into a wide
// vector, MSB first, and returns the NBITS-1 kept bits plus guard and
// sticky. Flags quotients outside the representable regime range.
// Assumes NBITS >= 4.
module f2p_pack
    import f2p_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int ES    = 1,
    localparam int EW   = (ES > 0) ? ES : 1
) (
    input  logic signed [KREG_W-1:0] k,
    input  logic [EW-1:0]            ex,
    input  logic [FMAN_W-1:0]        man,
    output logic [NBITS-2:0]         body,
    output logic                     guard,
    output logic                     sticky,
    output logic                     sat_hi,
    output logic                     sat_lo
);
    localparam int TW = ES + FMAN_W + 1;
    localparam int WB = NBITS + TW;

    logic [TW-1:0] tail;
    logic [WB-1:0] fill;
    logic [WB-1:0] wide;
    int            ki;
    int            rl;

    generate
        if (ES > 0) begin : g_tail_ex
            // stop bit equals the sign of k
            assign tail = {k[KREG_W-1], ex, man};
        end else begin : g_tail_noex
            assign tail = {k[KREG_W-1], man};
            logic unused_ex;
            assign unused_ex = ^ex;
        end
    endgenerate

    // build the left-aligned bit string and split kept/guard/sticky
    always_comb begin
        ki     = int'(k);
        sat_hi = ki > NBITS - 2;
        sat_lo = ki < -(NBITS - 2);
        rl     = (ki >= 0) ? ki + 1 : -ki;
        if (rl > NBITS - 1)
            rl = NBITS - 1;
        fill   = (ki >= 0) ? ~({WB{1'b1}} >> rl) : '0;
        wide   = ({{NBITS{1'b0}}, tail} << (NBITS - rl)) | fill;
        body   = wide[WB-1 -: NBITS-1];
        guard  = wide[WB-NBITS];
        sticky = |wide[WB-NBITS-1:0];
    end
endmodule

// File: rtl/f2p_round.sv
// Rounds the kept bits to nearest-even, clamps to maxpos/minpos, applies
// the sign by two's complement and substitutes zero / not-a-real codes.
// Assumes body/guard/sticky come from f2p_pack for the same word.
module f2p_round
    import f2p_pkg::*;
#(
    parameter int NBITS = 16
) (
    input  fcls_e             cls,
    input  logic              sign,
    input  logic [NBITS-2:0]  body,
    input  logic              guard,
    input  logic              sticky,
    input  logic              sat_hi,
    input  logic              sat_lo,
    output logic [NBITS-1:0]  posit
);
    logic             inc;
    logic [NBITS-1:0] sum;
    logic [NBITS-2:0] mag;
    logic [NBITS-1:0] pos;

    // round, clamp, sign and special-code selection
    always_comb begin
        inc = guard & (sticky | body[0]);
        sum = {1'b0, body} + {{(NBITS-1){1'b0}}, inc};
        mag = sum[NBITS-1] ? '1 : sum[NBITS-2:0];
        if (sat_hi)
            mag = '1;
        else if (sat_lo)
            mag = {{(NBITS-2){1'b0}}, 1'b1};
        pos = {1'b0, mag};
        case (cls)
            CLS_ZERO: posit = '0;
            CLS_NAR:  posit = {1'b1, {(NBITS-1){1'b0}}};
            default:  posit = sign ? (~pos + 1'b1) : pos;
        endcase
    end
endmodule

// File: rtl/f2p_conv.sv
// Two-stage single-precision to posit converter. Stage 1 registers the
// split fields; stage 2 registers the packed, rounded, signed result.
// Assumes in_valid is held low while rst_n is low.
module f2p_conv
    import f2p_pkg::*;
#(
    parameter int NBITS = 16,
    parameter int ES    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_float,
    output logic             out_valid,
    output logic [NBITS-1:0] out_posit
);
    localparam int EW   = (ES > 0) ? ES : 1;
    localparam int KMAX = NBITS - 2;
    localparam logic [NBITS-1:0] NAR    = {1'b1, {(NBITS-1){1'b0}}};
    localparam logic [NBITS-1:0] MAXPOS = {1'b0, {(NBITS-1){1'b1}}};

    fcls_e                    u_cls,  s1_cls;
    logic                     u_sign, s1_sign;
    logic signed [KREG_W-1:0] u_k,    s1_k;
    logic [EW-1:0]            u_ex,   s1_ex;
    logic [FMAN_W-1:0]        u_man,  s1_man;
    logic                     s1_valid;

    logic [NBITS-2:0] p_body;
    logic             p_guard, p_sticky, p_sat_hi, p_sat_lo;
    logic [NBITS-1:0] r_posit;

    f2p_unpack #(.ES(ES)) u_unpack (
        .f_in (in_float),
        .cls  (u_cls),
        .sign (u_sign),
        .k    (u_k),
        .ex   (u_ex),
        .man  (u_man)
    );

    // stage 1: hold the split fields of an accepted word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_cls   <= CLS_ZERO;
            s1_sign  <= 1'b0;
            s1_k     <= '0;
            s1_ex    <= '0;
            s1_man   <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_cls  <= u_cls;
                s1_sign <= u_sign;
                s1_k    <= u_k;
                s1_ex   <= u_ex;
                s1_man  <= u_man;
            end
        end
    end

    f2p_pack #(.NBITS(NBITS), .ES(ES)) u_pack (
        .k      (s1_k),
        .ex     (s1_ex),
        .man    (s1_man),
        .body   (p_body),
        .guard  (p_guard),
        .sticky (p_sticky),
        .sat_hi (p_sat_hi),
        .sat_lo (p_sat_lo)
    );

    f2p_round #(.NBITS(NBITS)) u_round (
        .cls    (s1_cls),
        .sign   (s1_sign),
        .body   (p_body),
        .guard  (p_guard),
        .sticky (p_sticky),
        .sat_hi (p_sat_hi),
        .sat_lo (p_sat_lo),
        .posit  (r_posit)
    );

    // stage 2: register the finished posit word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_posit <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid)
                out_posit <= r_posit;
        end
    end

    // every accepted word emerges two edges later
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    // no result without a word accepted two edges before
    assert_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));
    assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(s1_cls == CLS_ZERO) |-> out_posit == '0);
    assert_nar_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(s1_cls == CLS_NAR) |-> out_posit == NAR);
    assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(s1_cls == CLS_NUM && !s1_sign && (int'(s1_k) > KMAX))
        |-> out_posit == MAXPOS);
    assert_sign_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(s1_cls == CLS_NUM && s1_sign) |-> out_posit[NBITS-1]);
    assert_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(s1_cls == CLS_NUM) |-> (out_posit != '0) && (out_posit != NAR));
endmodule

// File: tb/f2p_conv_tb.sv
module f2p_conv_tb;
    localparam int N  = 16;
    localparam int ES = 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  in_float = '0;
    logic         out_valid;
    logic [N-1:0] out_posit;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [N-1:0] val;
        logic [31:0] f;
        string       tag;
    } exp_t;
    exp_t expq[$];

    f2p_conv #(.NBITS(N), .ES(ES)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_float  (in_float),
        .out_valid (out_valid),
        .out_posit (out_posit)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // bit-serial reference: generate the posit string one bit at a time
    function automatic logic [N-1:0] model(input logic [31:0] f);
        int e8, eu, k, exv, idx;
        bit b[0:63];
        logic [N-2:0] p;
        bit g, st;
        logic [N-1:0] r;
        e8 = int'(f[30:23]);
        if (e8 == 0) return '0;
        if (e8 == 255) return {1'b1, {(N-1){1'b0}}};
        eu = e8 - 127;
        k = (eu >= 0) ? eu / (1 << ES) : -((-eu + (1 << ES) - 1) / (1 << ES));
        exv = eu - k * (1 << ES);
        if (k > N - 2) r = {1'b0, {(N-1){1'b1}}};
        else if (k < -(N - 2)) r = 1;
        else begin
            foreach (b[i]) b[i] = 1'b0;
            idx = 0;
            if (k >= 0) begin
                for (int i = 0; i <= k; i++) begin b[idx] = 1'b1; idx++; end
                b[idx] = 1'b0; idx++;
            end else begin
                for (int i = 0; i < -k; i++) begin b[idx] = 1'b0; idx++; end
                b[idx] = 1'b1; idx++;
            end
            for (int i = ES - 1; i >= 0; i--) begin b[idx] = exv[i]; idx++; end
            for (int i = 22; i >= 0; i--) begin b[idx] = f[i]; idx++; end
            p = '0;
            for (int i = 0; i < N - 1; i++) p = {p[N-3:0], b[i]};
            g = b[N-1];
            st = 1'b0;
            for (int i = N; i < 64; i++) st = st | b[i];
            if (g && (st || p[0]) && !(&p)) p = p + 1'b1;
            r = {1'b0, p};
        end
        if (f[31]) r = ~r + 1'b1;
        return r;
    endfunction

    function automatic string tag_of(input logic [31:0] f);
        int e8, eu;
        e8 = int'(f[30:23]);
        eu = e8 - 127;
        if (e8 == 0) return "R1";
        if (e8 == 255) return "R2";
        if (eu >= (N - 1) * (1 << ES) || eu < -(N - 2) * (1 << ES)) return "R5";
        if (f[31]) return "R6";
        return "R3 R4";
    endfunction

    // drive one word at a negedge and queue its expected result
    task automatic send(input logic [31:0] f);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_float = f;
        e.due = cyc + 2;
        e.val = model(f);
        e.f   = f;
        e.tag = tag_of(f);
        expq.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_float = $urandom;
    endtask

    // monitor: sample outputs half a cycle after the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (expq.size() > 0 && expq[0].due == cyc) begin
                check(out_valid == 1'b1, "R8", 32'(out_valid), 32'd1);
                check(out_posit == expq[0].val, expq[0].tag, 32'(out_posit), 32'(expq[0].val));
                if (expq[0].f[30:23] != 8'd0 && expq[0].f[30:23] != 8'hFF)
                    check(out_posit != '0 && out_posit != {1'b1, {(N-1){1'b0}}}, "R7",
                          32'(out_posit), 32'(expq[0].val));
                void'(expq.pop_front());
            end else begin
                check(out_valid == 1'b0, "R8", 32'(out_valid), 32'd0);
            end
        end
    end

    // watchdog
    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    logic [31:0] directed [0:17] = '{
        32'h0000_0000, 32'h8000_0000, 32'h0000_0001,   // R1 zero, -zero, subnormal
        32'h7FC0_0000, 32'h7F80_0000, 32'hFF80_0000,   // R2 NaN, +inf, -inf
        32'h3F80_0000, 32'hBF80_0000,                  // R3 1.0 -> 0x4000, R6 -1.0 -> 0xC000
        32'h3F80_0400, 32'h3F80_0C00, 32'h3F80_0401,   // R4 tie to even, tie up, above tie
        32'h7F00_0000, 32'hFF00_0000,                  // R5 maxpos, -maxpos
        32'h0080_0000, 32'h8080_0000,                  // R5 minpos, -minpos
        32'h4D80_0000, 32'h3180_0000,                  // R3 run fills word, minpos edge
        32'h3E40_0000                                  // R3 negative k
    };

    initial begin
        void'($urandom(32'h5EED_F2A7));
        repeat (3) @(negedge clk);
        // R9: cleared by reset
        check(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0);
        check(out_posit == '0, "R9", 32'(out_posit), 32'd0);
        rst_n = 1'b1;
        // hand-computed anchors for R3 and R5
        check(model(32'h3F80_0000) == 16'h4000, "R3", 32'(model(32'h3F80_0000)), 32'h4000);
        check(model(32'h7F00_0000) == 16'h7FFF, "R5", 32'(model(32'h7F00_0000)), 32'h7FFF);
        check(model(32'h8080_0000) == 16'hFFFF, "R6", 32'(model(32'h8080_0000)), 32'hFFFF);
        check(model(32'h3F80_0400) == 16'h4000, "R4", 32'(model(32'h3F80_0400)), 32'h4000);
        check(model(32'h3F80_0C00) == 16'h4002, "R4", 32'(model(32'h3F80_0C00)), 32'h4002);
        idle();
        foreach (directed[i]) send(directed[i]);
        idle();
        idle();
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] f;
            int sel;
            sel = int'($urandom % 8);
            if (sel < 2) f = $urandom;
            else begin
                f[31]    = $urandom % 2;
                f[30:23] = 8'(127 + int'($urandom % 61) - 30);
                f[22:0]  = 23'($urandom);
                if (sel == 7) f[9:0] = 10'h200;
            end
            if ($urandom % 4 == 0) idle();
            send(f);
        end
        idle();
        repeat (4) @(negedge clk);
        done = 1'b1;
        check(expq.size() == 0, "R8", 32'(expq.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule